// File: doc/BRIEF.md
# Fixed-Point Product Saturation Unit

This block takes the full-width signed product of two 16-bit fixed-point operands and narrows it back to 16 bits in the operands' own Q format. That lets the result go back into storage or into the next multiply. The product is 31 bits wide: one sign bit plus twice the integer bits and twice the fractional bits of an operand. The surplus fractional bits at the bottom are dropped by plain truncation. The surplus integer bits at the top are removed with saturation. If the value does not fit the 16-bit field, the output is pinned to the largest positive or the most negative code.

The range test is a uniformity check. The value fits when every product bit from the position that becomes the output sign bit up to the product's own sign bit holds the same value. The clamp code is built from the product's sign bit alone: the output sign bit takes that sign, and every lower output bit takes its inverse. The fractional width is a parameter. The result, its valid flag and an overflow flag are registered, so they appear one clock after the product is presented.

Top module: `prodsat_unit`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first valid product is accepted, `out_valid`, `out_ovf` and `out_data` are all zero.
- R2: `out_valid` in a cycle equals `in_valid` sampled at the previous rising clock edge (one cycle of latency).
- R3: For an in-range product accepted with `in_valid` high, `out_data` one cycle later equals product bits [FRAC_W+15:FRAC_W]. With the default FRAC_W of 11, that field is bits [26:11].
- R4: If the product's sign bit (bit 30) is 0 and the checked bits [30:FRAC_W+15] are not all equal, the output is 16'h7FFF.
- R5: If the product's sign bit is 1 and the checked bits are not all equal, the output is 16'h8000.
- R6: `out_ovf` is high in exactly those cycles where `out_valid` is high and the accepted product failed the uniformity check. It is low in every other cycle.
- R7: A cycle with `in_valid` low leaves `out_data` unchanged, whatever `in_prod` carries, and drives `out_valid` and `out_ovf` low.
- R8: The discarded bits [FRAC_W-1:0] have no effect on `out_data` or `out_ovf`. Negative values therefore round toward minus infinity: the result equals the arithmetic right shift of the product by FRAC_W.
- R9: The boundary codes pass without overflow. A product whose shifted value is exactly 32767 or exactly -32768 yields 16'h7FFF or 16'h8000 with `out_ovf` low. Values one step beyond either bound set `out_ovf`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Marks `in_prod` as a product to convert this cycle |
| in_prod | input | 31 | Full-width signed product of two 16-bit operands |
| out_valid | output | 1 | Registered result valid, one cycle after `in_valid` |
| out_data | output | 16 | Truncated and saturated result, same Q format as the operands |
| out_ovf | output | 1 | High when the presented result was clamped |

## Verification
The assertions assume that `in_prod` is a genuine 31-bit two's-complement value and that `in_valid` is never unknown after reset. They make no assumption about the product's range, so overflow in either direction is legal input. The stimulus drives every input on the falling clock edge and holds it there. It drives products both as real operand pairs and as raw bit patterns placed just inside and just outside each saturation bound. It also loads garbage into `in_prod` during idle cycles to show that `in_prod` is ignored while `in_valid` is low. One corner is left out of the stimulus: the operand pair of two most-negative values, whose true product cannot be represented in 31 bits.

// File: rtl/prodsat_pkg.sv
package prodsat_pkg;

  // Widest vector the helper functions handle; callers zero-extend into it.
  localparam int unsigned VEC_W = 64;

  // True when the low n bits of v all carry the same value.
  function automatic logic bits_uniform(input logic [VEC_W-1:0] v, input int unsigned n);
    logic same;
    same = 1'b1;
    for (int unsigned i = 1; i < VEC_W; i++) begin
      if (i < n && v[i] != v[0]) same = 1'b0;
    end
    return same;
  endfunction

  // Saturation code of width w: top bit is sgn, all lower bits are ~sgn.
  function automatic logic [VEC_W-1:0] sat_code(input logic sgn, input int unsigned w);
    logic [VEC_W-1:0] code;
    code = '0;
    for (int unsigned i = 0; i < VEC_W; i++) begin
      if (i + 1 < w)       code[i] = ~sgn;
      else if (i + 1 == w) code[i] = sgn;
    end
    return code;
  endfunction

endpackage

// File: rtl/prodsat_detect.sv
module prodsat_detect
  import prodsat_pkg::*;
#(
  parameter int unsigned CHK_W = 5
) (
  input  logic [CHK_W-1:0] chk_bits,   // output sign position up to product sign
  output logic             range_bad
);

  generate
    if (CHK_W <= 1) begin : g_no_surplus
      // Nothing above the output sign bit: overflow cannot happen.
      assign range_bad = 1'b0;
    end else begin : g_uniform
      logic [VEC_W-1:0] chk_ext;
      assign chk_ext   = {{(VEC_W-CHK_W){1'b0}}, chk_bits};
      assign range_bad = ~bits_uniform(chk_ext, CHK_W);
    end
  endgenerate

endmodule

// File: rtl/prodsat_clamp.sv
module prodsat_clamp
  import prodsat_pkg::*;
#(
  parameter int unsigned OUT_W = 16
) (
  input  logic [OUT_W-1:0] kept_field,
  input  logic             prod_sign,
  input  logic             range_bad,
  output logic [OUT_W-1:0] result
);

  logic [VEC_W-1:0] code_full;
  logic [OUT_W-1:0] clamp_val;

  assign code_full = sat_code(prod_sign, OUT_W);
  assign clamp_val = code_full[OUT_W-1:0];
  assign result    = range_bad ? clamp_val : kept_field;

endmodule

// File: rtl/prodsat_stage.sv
module prodsat_stage #(
  parameter int unsigned OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [OUT_W-1:0] nxt_data,
  input  logic             nxt_ovf,
  output logic             q_valid,
  output logic [OUT_W-1:0] q_data,
  output logic             q_ovf
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_data  <= '0;
      q_ovf   <= 1'b0;
    end else begin
      q_valid <= load;
      q_ovf   <= load & nxt_ovf;
      if (load) q_data <= nxt_data;
    end
  end

endmodule

// File: rtl/prodsat_unit.sv
module prodsat_unit #(
  parameter int unsigned IN_W   = 16,
  parameter int unsigned FRAC_W = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [2*IN_W-2:0]   in_prod,
  output logic                out_valid,
  output logic [IN_W-1:0]     out_data,
  output logic                out_ovf
);

  localparam int unsigned PROD_W  = 2*IN_W - 1;
  localparam int unsigned KEEP_LO = FRAC_W;
  localparam int unsigned KEEP_HI = FRAC_W + IN_W - 1;
  localparam int unsigned CHK_W   = PROD_W - KEEP_HI;
  localparam logic [IN_W-1:0] POS_MAX = {1'b0, {(IN_W-1){1'b1}}};
  localparam logic [IN_W-1:0] NEG_MIN = {1'b1, {(IN_W-1){1'b0}}};

  // Named internal events for the assertions
  logic            range_bad;
  logic            prod_sign;
  logic            frac_nonzero;
  logic [IN_W-1:0] kept_field;
  logic [IN_W-1:0] narrowed;

  assign prod_sign    = in_prod[PROD_W-1];
  assign kept_field   = in_prod[KEEP_HI:KEEP_LO];
  assign frac_nonzero = |in_prod[KEEP_LO-1:0];

  prodsat_detect #(.CHK_W(CHK_W)) u_detect (
    .chk_bits  (in_prod[PROD_W-1:KEEP_HI]),
    .range_bad (range_bad)
  );

  prodsat_clamp #(.OUT_W(IN_W)) u_clamp (
    .kept_field (kept_field),
    .prod_sign  (prod_sign),
    .range_bad  (range_bad),
    .result     (narrowed)
  );

  prodsat_stage #(.OUT_W(IN_W)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (in_valid),
    .nxt_data (narrowed),
    .nxt_ovf  (range_bad),
    .q_valid  (out_valid),
    .q_data   (out_data),
    .q_ovf    (out_ovf)
  );

  // R2: valid follows input valid after one edge
  a_r2_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_idle_latency: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R3: in-range value passes the kept field unchanged
  a_r3_kept_field: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !range_bad) |=> (out_data == $past(kept_field) && !out_ovf));

  // R4: positive overflow pins to the maximum code
  a_r4_pos_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && range_bad && !prod_sign) |=> (out_data == POS_MAX && out_ovf));

  // R5: negative overflow pins to the minimum code
  a_r5_neg_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && range_bad && prod_sign) |=> (out_data == NEG_MIN && out_ovf));

  // R6: overflow flag only alongside a valid result
  a_r6_ovf_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_ovf |-> out_valid);

  // R7: idle cycles hold the data
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));

  // R8: dropped fraction bits never cause overflow by themselves
  a_r8_frac_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && frac_nonzero && !range_bad) |=> !out_ovf);

endmodule

// File: tb/tb_prodsat_unit.sv
module tb_prodsat_unit;

  localparam int IN_W   = 16;
  localparam int FRAC_W = 11;
  localparam int PROD_W = 2*IN_W - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic [PROD_W-1:0] in_prod = '0;
  logic              out_valid;
  logic [IN_W-1:0]   out_data;
  logic              out_ovf;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2 clk = ~clk;   // 250 MHz

  prodsat_unit #(.IN_W(IN_W), .FRAC_W(FRAC_W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_prod(in_prod),
    .out_valid(out_valid), .out_data(out_data), .out_ovf(out_ovf)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference: arithmetic shift of the signed product, then range compare.
  task automatic model(input logic [PROD_W-1:0] p, output logic [IN_W-1:0] d, output logic o);
    longint sv, q;
    sv = longint'(signed'(p));
    q  = sv >>> FRAC_W;
    if (q > 32767)        begin d = 16'h7FFF; o = 1'b1; end
    else if (q < -32768)  begin d = 16'h8000; o = 1'b1; end
    else                  begin d = q[15:0];  o = 1'b0; end
  endtask

  function automatic logic [PROD_W-1:0] mul(input logic [15:0] a, input logic [15:0] b);
    longint r;
    r = longint'(signed'(a)) * longint'(signed'(b));
    return r[PROD_W-1:0];
  endfunction

  function automatic logic [PROD_W-1:0] from_q(input longint q, input longint frac);
    longint r;
    r = (q <<< FRAC_W) + frac;
    return r[PROD_W-1:0];
  endfunction

  // Present one product, then sample just after the capturing edge.
  task automatic drive(input logic [PROD_W-1:0] p, input logic v);
    @(negedge clk);
    in_prod  = p;
    in_valid = v;
    @(posedge clk);
    #1;
  endtask

  task automatic convert_and_check(input string req, input logic [PROD_W-1:0] p);
    logic [IN_W-1:0] ed;
    logic eo;
    model(p, ed, eo);
    drive(p, 1'b1);
    chk({req, " valid"}, 32'(out_valid), 32'd1);
    chk({req, " data"},  32'(out_data),  32'(ed));
    chk({req, " ovf"},   32'(out_ovf),   32'(eo));
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset valid", 32'(out_valid), 32'd0);
    chk("R1 reset data",  32'(out_data),  32'd0);
    chk("R1 reset ovf",   32'(out_ovf),   32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(31'h7FFF_FFFF, 1'b0);
    chk("R1 after reset data", 32'(out_data), 32'd0);
    chk("R1 after reset valid", 32'(out_valid), 32'd0);
  endtask

  task automatic t_in_range;
    convert_and_check("R3 1.0*1.5", mul(16'h0800, 16'h0C00));
    chk("R3 1.0*1.5 literal", 32'(out_data), 32'h0C00);
    convert_and_check("R3 -2.0*1.25", mul(16'hF000, 16'h0A00));
    chk("R3 -2.0*1.25 literal", 32'(out_data), 32'hEC00);
    convert_and_check("R3 small", mul(16'h0013, 16'hFF9D));
  endtask

  task automatic t_pos_ovf;
    convert_and_check("R4 max*max", mul(16'h7FFF, 16'h7FFF));
    chk("R4 max*max literal", 32'(out_data), 32'h7FFF);
    convert_and_check("R4 neg*neg", mul(16'hC000, 16'hC000));
    chk("R4 neg*neg ovf", 32'(out_ovf), 32'd1);
  endtask

  task automatic t_neg_ovf;
    convert_and_check("R5 max*min", mul(16'h7FFF, 16'h8000));
    chk("R5 max*min literal", 32'(out_data), 32'h8000);
    convert_and_check("R5 mixed", mul(16'h4000, 16'hB000));
  endtask

  task automatic t_truncation;
    convert_and_check("R8 pos frac", from_q(5, 2047));
    chk("R8 pos frac literal", 32'(out_data), 32'h0005);
    convert_and_check("R8 neg frac", from_q(-5, 2047));
    chk("R8 neg frac literal", 32'(out_data), 32'hFFFB);
    convert_and_check("R8 top frac no ovf", from_q(32767, 2047));
    chk("R8 top frac ovf", 32'(out_ovf), 32'd0);
  endtask

  task automatic t_bounds;
    convert_and_check("R9 q=32767", from_q(32767, 0));
    chk("R9 q=32767 literal", {15'd0, out_ovf, out_data}, {15'd0, 1'b0, 16'h7FFF});
    convert_and_check("R9 q=32768", from_q(32768, 0));
    chk("R9 q=32768 literal", {15'd0, out_ovf, out_data}, {15'd0, 1'b1, 16'h7FFF});
    convert_and_check("R9 q=-32768", from_q(-32768, 0));
    chk("R9 q=-32768 literal", {15'd0, out_ovf, out_data}, {15'd0, 1'b0, 16'h8000});
    convert_and_check("R9 q=-32769", from_q(-32769, 0));
    chk("R9 q=-32769 literal", {15'd0, out_ovf, out_data}, {15'd0, 1'b1, 16'h8000});
  endtask

  task automatic t_idle_hold;
    convert_and_check("R7 seed", mul(16'h7FFF, 16'h7FFF));
    drive(31'h0000_1234, 1'b0);
    chk("R7 idle data",  32'(out_data),  32'h7FFF);
    chk("R2 idle valid", 32'(out_valid), 32'd0);
    chk("R6 idle ovf",   32'(out_ovf),   32'd0);
    drive(31'h4000_0000, 1'b0);
    chk("R7 idle data 2", 32'(out_data), 32'h7FFF);
  endtask

  task automatic t_stream;
    for (int i = 0; i < 40; i++) begin
      logic [15:0] a, b;
      a = 16'(i * 16'h0731 + 16'h0123);
      b = 16'(16'hF100 - i * 16'h0477);
      if (a == 16'h8000 && b == 16'h8000) b = 16'h7FFF;
      convert_and_check("R6 stream", mul(a, b));
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R2 watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    t_reset();
    t_in_range();
    t_pos_ovf();
    t_neg_ovf();
    t_truncation();
    t_bounds();
    t_idle_hold();
    t_stream();
    drive('0, 1'b0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule